// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit with Guard Bits

This block multiplies pairs of N-bit two's-complement fractional operands and sums the products in a register that is wider than the data path. The value range of each operand is [-1, 1-2^-(N-1)]. Every product is kept at its full width. The accumulator adds GUARD high-order bits above the product, so a running sum may go beyond [-1, 1) while terms are still being added, and it still comes back exact when later terms pull it into range.

The wide value is cut back to N bits only when a read strobe copies it to the output register. The low N-1 fractional bits are dropped, either by plain truncation or by rounding to the nearest output level. A value that does not fit N bits after that step is handled in one of three ways, chosen when the read is issued: clip it to the nearest limit, replace it with zero, or keep its low N bits, which reverses the sign. An overflow flag marks any read whose value did not fit.

A typical caller clears the accumulator, or loads it with its first product, then issues one accumulate strobe per term, and reads the result once the sum is complete.

Top module: `fxp_guard_mac`

## Requirements
- R1: While reset is held, and in the first cycles after it, `result` is 0 and `ovf` is 0, and the accumulator holds 0.
- R2: An accumulate strobe adds the exact 2N-bit product `op_a*op_b`, which has 2N-2 fractional bits. No precision is lost before the read.
- R3: The product (-1)x(-1) is taken as +1 and never as a negative number. Reading it alone gives an overflow. Adding (-1)x(0.5) to it gives exactly 0.5 (0x4000 for N=16) with no overflow.
- R4: With GUARD=4 the accumulator spans [-32, 32). Sixteen products of +1 followed by sixteen products of (-1)x(1-2^-15) read back exactly as 16 LSB.
- R5: `clr` alone sets the accumulator to 0 on the next edge. With neither `clr` nor `acc_en`, the accumulator holds its value whatever the operands do.
- R6: `clr` and `acc_en` in the same cycle load the accumulator with the current product alone. `acc_en` alone adds to the stored sum.
- R7: `rnd_sel`=0 truncates: the N-1 low fractional bits are dropped, which rounds toward minus infinity.
- R8: `rnd_sel`=1 adds half an output LSB before dropping the low bits, so ties round upward (+0.5 LSB becomes 1, -0.5 LSB becomes 0).
- R9: `ovf_sel`=00 (and 11) saturates: a value that does not fit becomes 0x7FFF..F or 0x800..0, following its sign.
- R10: `ovf_sel`=01 zeroes: a value that does not fit becomes 0.
- R11: `ovf_sel`=10 wraps: the low N bits of the reduced value are kept, so +1 reads as 0x8000.
- R12: `result` and `ovf` change only on the edge that ends a cycle with `rd` high. `ovf` is high only for the single cycle after such a read, and only when the rounded or truncated value lay outside the N-bit range. `result` holds between reads.
- R13: A read leaves the accumulator unchanged, so two reads in a row give the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clr | input | 1 | Clear the accumulator |
| acc_en | input | 1 | Add `op_a*op_b` to the accumulator |
| rd | input | 1 | Reduce the accumulator to N bits and register it on `result` |
| rnd_sel | input | 1 | 0 selects truncation, 1 selects rounding |
| ovf_sel | input | 2 | 00 or 11 selects saturation, 01 selects zeroing, 10 selects wraparound |
| op_a | input | DW | Operand A, a two's-complement fraction |
| op_b | input | DW | Operand B, a two's-complement fraction |
| result | output | DW | Reduced result of the last read |
| ovf | output | 1 | High for one cycle after a read whose value was out of range |

## Verification
The accumulator cannot be seen directly, so a wrong bit inside it shows up only at the next read. That read comes one edge after `rd`, and the bench places reads right after each sequence of operations so that such errors surface at once. A missing guard bit or a sign error in the product shows up as a wrong sign or a false `ovf` on the reads after the -1x-1 and sixteen-term runs. A rounding offset that is off by one shows up on the two exact half-LSB ties. Each mode is read on the same accumulator value, so an error in the overflow handling shows up as a single wrong `result` next to a correct `ovf`.

// File: rtl/fxp_mac_pkg.sv
package fxp_mac_pkg;

  typedef enum logic [1:0] {
    OVF_SAT  = 2'd0,
    OVF_ZERO = 2'd1,
    OVF_WRAP = 2'd2,
    OVF_SAT2 = 2'd3
  } ovf_mode_e;

endpackage

// File: rtl/mac_rst_sync.sv
module mac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int DW = 16,
  localparam int PW = 2 * DW
) (
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  output logic [PW-1:0] prod
);
  logic signed [DW-1:0] sa;
  logic signed [DW-1:0] sb;
  logic signed [PW-1:0] sp;

  always_comb begin
    sa = $signed(op_a);
    sb = $signed(op_b);
    sp = PW'(sa) * PW'(sb);
    prod = sp;
  end
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int DW    = 16,
  parameter int GUARD = 4,
  localparam int PW = 2 * DW,
  localparam int AW = PW + GUARD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          acc_en,
  input  logic [PW-1:0] prod,
  output logic [AW-1:0] acc_q
);
  logic [AW-1:0] prod_ext;
  logic [AW-1:0] base;
  logic [AW-1:0] acc_d;
  logic          acc_ce;

  always_comb begin
    prod_ext = {{GUARD{prod[PW-1]}}, prod};
    base     = clr ? '0 : acc_q;
    acc_d    = acc_en ? (base + prod_ext) : base;
    acc_ce   = clr | acc_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_ce) acc_q <= acc_d;
  end

  // R5: a clear on its own empties the accumulator
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !acc_en) |=> (acc_q == '0));

  // R5: with no strobe the accumulator keeps its value
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !acc_en) |=> $stable(acc_q));

  // R6: clear together with accumulate loads the product alone
  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && acc_en) |=> (acc_q == $past(prod_ext)));
endmodule

// File: rtl/mac_quant.sv
module mac_quant
  import fxp_mac_pkg::*;
#(
  parameter int DW    = 16,
  parameter int GUARD = 4,
  localparam int PW = 2 * DW,
  localparam int AW = PW + GUARD,
  localparam int SH = DW - 1
) (
  input  logic [AW-1:0] acc,
  input  logic          rnd_sel,
  input  ovf_mode_e     mode,
  output logic [DW-1:0] res,
  output logic          fits
);
  localparam logic [AW:0]   HALF  = (AW+1)'(1) << (SH - 1);
  localparam logic [DW-1:0] Q_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] Q_MIN = {1'b1, {(DW-1){1'b0}}};

  logic [AW:0]        add_v;
  logic signed [AW:0] ext;
  logic signed [AW:0] q;
  logic [AW-DW+1:0]   hi;

  always_comb begin
    add_v = rnd_sel ? HALF : '0;
    ext   = $signed({acc[AW-1], acc}) + $signed(add_v);
    q     = ext >>> SH;
    hi    = q[AW:DW-1];
    fits  = (&hi) | ~(|hi);
    unique case (mode)
      OVF_ZERO: res = fits ? q[DW-1:0] : '0;
      OVF_WRAP: res = q[DW-1:0];
      default:  res = fits ? q[DW-1:0] : (q[AW] ? Q_MIN : Q_MAX);
    endcase
  end
endmodule

// File: rtl/fxp_guard_mac.sv
module fxp_guard_mac
  import fxp_mac_pkg::*;
#(
  parameter int DW    = 16,
  parameter int GUARD = 4,
  localparam int PW = 2 * DW,
  localparam int AW = PW + GUARD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          acc_en,
  input  logic          rd,
  input  logic          rnd_sel,
  input  logic [1:0]    ovf_sel,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  output logic [DW-1:0] result,
  output logic          ovf
);
  localparam logic [DW-1:0] Q_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] Q_MIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [PW-1:0] P_ONE = PW'(1) << (PW - 2);

  logic          rst_sync_n;
  logic [PW-1:0] prod_w;
  logic [AW-1:0] acc_w;
  logic [DW-1:0] quant_w;
  logic          fits_w;
  ovf_mode_e     mode_w;
  logic [DW-1:0] res_d, res_q;
  logic          ovf_d, ovf_q;

  mac_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  mac_mult #(.DW(DW)) i_mult (
    .op_a(op_a), .op_b(op_b), .prod(prod_w)
  );

  mac_accum #(.DW(DW), .GUARD(GUARD)) i_accum (
    .clk(clk), .rst_n(rst_sync_n), .clr(clr), .acc_en(acc_en),
    .prod(prod_w), .acc_q(acc_w)
  );

  always_comb begin
    mode_w = ovf_mode_e'(ovf_sel);
  end

  mac_quant #(.DW(DW), .GUARD(GUARD)) i_quant (
    .acc(acc_w), .rnd_sel(rnd_sel), .mode(mode_w),
    .res(quant_w), .fits(fits_w)
  );

  always_comb begin
    res_d = rd ? quant_w : res_q;
    ovf_d = rd & ~fits_w;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      res_q <= res_d;
      ovf_q <= ovf_d;
    end
  end

  assign result = res_q;
  assign ovf    = ovf_q;

  // R3: minus one squared gives plus one at full width
  a_r3_minus_one_square: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_a == Q_MIN && op_b == Q_MIN) |-> (prod_w == P_ONE));

  // R12: the flag is a one-cycle pulse that follows a read
  a_r12_ovf_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd |=> !ovf);

  // R12: the output holds between reads
  a_r12_result_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd |=> $stable(result));

  // R9: a saturated read lands on a limit
  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd && (ovf_sel == 2'b00)) |=> (!ovf || result == Q_MAX || result == Q_MIN));

  // R10: a zeroed read gives zero
  a_r10_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd && (ovf_sel == 2'b01)) |=> (!ovf || result == '0));
endmodule

// File: tb/test_fxp_guard_mac.sv
module test_fxp_guard_mac;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0, acc_en = 1'b0, rd = 1'b0, rnd_sel = 1'b0;
  logic [1:0]    ovf_sel = 2'b00;
  logic [DW-1:0] op_a = '0, op_b = '0;
  logic [DW-1:0] result;
  logic          ovf;

  int n_vec = 0;
  int n_bad = 0;
  longint acc_m = 0;
  bit done = 1'b0;

  fxp_guard_mac #(.DW(DW), .GUARD(4)) i_fxp_guard_mac (
    .clk(clk), .rst_n(rst_n), .clr(clr), .acc_en(acc_en), .rd(rd),
    .rnd_sel(rnd_sel), .ovf_sel(ovf_sel), .op_a(op_a), .op_b(op_b),
    .result(result), .ovf(ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input longint got, input longint exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic do_op(input bit c, input bit e, input logic [DW-1:0] a, input logic [DW-1:0] b);
    longint sa, sb;
    clr = c; acc_en = e; op_a = a; op_b = b;
    @(negedge clk);
    clr = 1'b0; acc_en = 1'b0;
    op_a = ~a; op_b = b ^ 16'h5a5a;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (c) acc_m = 0;
    if (e) acc_m = acc_m + sa * sb;
  endtask

  task automatic do_read(input string req, input bit r, input logic [1:0] m);
    longint t, q;
    bit fit;
    logic [DW-1:0] exp_res;
    t = acc_m + (r ? (longint'(1) <<< (DW-2)) : 0);
    q = t >>> (DW-1);
    fit = (q >= -(longint'(1) <<< (DW-1))) && (q < (longint'(1) <<< (DW-1)));
    case (m)
      2'b01:   exp_res = fit ? q[DW-1:0] : '0;
      2'b10:   exp_res = q[DW-1:0];
      default: exp_res = fit ? q[DW-1:0] : (q < 0 ? 16'h8000 : 16'h7fff);
    endcase
    rd = 1'b1; rnd_sel = r; ovf_sel = m;
    @(negedge clk);
    rd = 1'b0; rnd_sel = ~r; ovf_sel = ~m;
    check({req, " result"}, longint'(result), longint'(exp_res));
    check({req, " ovf"}, longint'(ovf), longint'(!fit));
  endtask

  task automatic t_reset();
    check("R1 reset result", longint'(result), 0);
    check("R1 reset ovf", longint'(ovf), 0);
    do_read("R1 accumulator empty", 1'b0, 2'b00);
  endtask

  task automatic t_product();
    do_op(1'b1, 1'b1, 16'h4000, 16'h6000);
    do_read("R2 product 0.375", 1'b0, 2'b00);
    check("R2 exact 0x3000", longint'(result), 64'h3000);
    do_op(1'b1, 1'b1, 16'h1234, 16'hc321);
    do_op(1'b0, 1'b1, 16'h7fff, 16'h0003);
    do_read("R6 sum truncated", 1'b0, 2'b00);
    do_read("R8 sum rounded", 1'b1, 2'b00);
  endtask

  task automatic t_ties();
    do_op(1'b1, 1'b1, 16'h0001, 16'h4000);
    do_read("R7 +half truncated", 1'b0, 2'b00);
    check("R7 +half -> 0", longint'(result), 0);
    do_read("R8 +half rounded", 1'b1, 2'b00);
    check("R8 +half -> 1", longint'(result), 1);
    do_op(1'b1, 1'b1, 16'hffff, 16'h4000);
    do_read("R7 -half truncated", 1'b0, 2'b00);
    check("R7 -half -> ffff", longint'(result), 64'hffff);
    do_read("R8 -half rounded", 1'b1, 2'b00);
    check("R8 -half -> 0", longint'(result), 0);
  endtask

  task automatic t_minus_one();
    do_op(1'b1, 1'b1, 16'h8000, 16'h8000);
    do_read("R9 saturate +1", 1'b0, 2'b00);
    check("R9 max", longint'(result), 64'h7fff);
    do_read("R10 zero +1", 1'b0, 2'b01);
    check("R10 zero", longint'(result), 0);
    do_read("R11 wrap +1", 1'b0, 2'b10);
    check("R11 sign reversed", longint'(result), 64'h8000);
    do_read("R9 mode 11 saturates", 1'b1, 2'b11);
    do_op(1'b0, 1'b1, 16'h8000, 16'h4000);
    do_read("R3 back to 0.5", 1'b0, 2'b00);
    check("R3 0x4000", longint'(result), 64'h4000);
  endtask

  task automatic t_guard();
    do_op(1'b1, 1'b0, 16'h0, 16'h0);
    for (int i = 0; i < 16; i++) do_op(1'b0, 1'b1, 16'h8000, 16'h8000);
    do_read("R4 sixteen full-scale", 1'b0, 2'b00);
    for (int i = 0; i < 16; i++) do_op(1'b0, 1'b1, 16'h8000, 16'h7fff);
    do_read("R4 guard return", 1'b0, 2'b00);
    check("R4 16 LSB", longint'(result), 64'h0010);
    do_op(1'b1, 1'b1, 16'h8000, 16'h7fff);
    do_op(1'b0, 1'b1, 16'h8000, 16'h7fff);
    do_op(1'b0, 1'b1, 16'h8000, 16'h7fff);
    do_read("R9 negative saturate", 1'b1, 2'b00);
    check("R9 min", longint'(result), 64'h8000);
    do_read("R11 negative wrap", 1'b0, 2'b10);
  endtask

  task automatic t_hold_clear();
    do_op(1'b1, 1'b1, 16'h2000, 16'h3000);
    do_op(1'b0, 1'b0, 16'h7fff, 16'h7fff);
    do_op(1'b0, 1'b0, 16'h8000, 16'h8000);
    do_read("R5 hold without strobe", 1'b0, 2'b00);
    do_read("R13 second read same", 1'b0, 2'b00);
    check("R13 value", longint'(result), 64'h0c00);
    check("R12 ovf low in idle", longint'(ovf), 0);
    @(negedge clk);
    check("R12 result held", longint'(result), 64'h0c00);
    check("R12 ovf stays low", longint'(ovf), 0);
    do_op(1'b1, 1'b0, 16'h7fff, 16'h7fff);
    do_read("R5 clear alone", 1'b1, 2'b00);
    check("R5 cleared", longint'(result), 0);
    do_op(1'b1, 1'b1, 16'h8000, 16'h8000);
    do_read("R12 ovf after read", 1'b0, 2'b00);
    @(negedge clk);
    check("R12 ovf one cycle", longint'(ovf), 0);
    check("R12 result kept", longint'(result), 64'h7fff);
  endtask

  initial begin : watchdog
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_product();
    t_ties();
    t_minus_one();
    t_guard();
    t_hold_clear();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule